// File: doc/BRIEF.md
# USB Host Transaction Status Capture

This block sits at the tail of a USB host transaction engine. When the engine finishes a transaction, it pulses a done strobe. At that strobe the block writes a 16-bit status word that records how the transaction ended. The word covers:

- the handshake the device returned;
- whether the response timed out;
- whether a packet check failed;
- which DATA toggle arrived;
- whether an IN data stage brought back more bytes than the programmed count, fewer bytes, or exactly that many.

The word keeps its value until the next strobe. Software or a neighbouring unit reads it through a plain read port. The length flags come from comparing the received byte count against the expected count inside the block. Failures are split into classes that do not overlap:

- Packet-check problems set the error flag.
- Timeouts, NAK, STALL and length mismatches have their own flags.
- Length mismatches never set the error flag.

Top module: `usbh_xfer_status`

## Requirements
- R1: After a clock edge with `rst_n` low, every bit of the status word is 0.
- R2: On a cycle where `xfer_done` is low, the status word keeps its previous value.
- R3: When `xfer_done` is high, `in_stage` is 1 and `rx_count` > `exp_count`, bit 11 (overflow) becomes 1. Otherwise bit 11 becomes 0.
- R4: When `xfer_done` is high, `in_stage` is 1 and `rx_count` < `exp_count`, bit 10 (underflow) becomes 1. Otherwise bit 10 becomes 0.
- R5: Bit 5 (length mismatch) is written with the OR of the new overflow and underflow values. Equal counts on an IN stage leave bits 11, 10 and 5 all 0.
- R6: When `xfer_done` is high and `in_stage` is 0, bits 11, 10 and 5 are written as 0 whatever the counts are.
- R7: `hs_code` uses this encoding: 0 = no handshake, 1 = ACK, 2 = NAK, 3 = STALL. At a strobe, bit 0 is set for ACK, bit 6 for NAK and bit 7 for STALL. Exactly these handshake bits are written and the others are cleared.
- R8: At a strobe, bit 2 (timeout) takes the value of `timeout`.
- R9: At a strobe, bit 1 (error) is written with the OR of `crc5_err`, `crc16_err` and `pid_err`. Timeout, NAK, STALL and length mismatch do not set it.
- R10: At a strobe, bit 3 (sequence) takes `rx_toggle` (1 = DATA1, 0 = DATA0) only if the handshake is ACK and bit 1 is being written 0. Otherwise bit 3 is written 0.
- R11: Bits 15 to 12, 9, 8 and 4 always read 0.
- R12: `rd_data` equals the status word in the same cycle while `rd_en` is high, and is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_done | input | 1 | Transaction-finished strobe, one cycle |
| hs_code | input | 2 | Handshake outcome: 0 none, 1 ACK, 2 NAK, 3 STALL |
| timeout | input | 1 | Device response timed out |
| crc5_err | input | 1 | Token CRC5 check failed |
| crc16_err | input | 1 | Data CRC16 check failed |
| pid_err | input | 1 | Unexpected packet type received |
| rx_toggle | input | 1 | Received DATA toggle, 1 = DATA1 |
| in_stage | input | 1 | Transaction carried an IN data stage |
| rx_count | input | CNT_W | Bytes received in the data stage |
| exp_count | input | CNT_W | Programmed expected byte count |
| rd_en | input | 1 | Read enable for the status port |
| rd_data | output | 16 | Status word, zero when not read |

## Verification
Directed transactions target each flag in isolation:

- Each handshake code is sent on its own.
- Counts are set one above, one below and equal to the expected value, first with `in_stage` set and then with it cleared. This separates the greater-than, less-than and equal comparisons and shows the length gate working.
- Each check error is combined with an ACK and with DATA1. This shows that the error flag suppresses the sequence bit and that timeout and length conditions stay out of the error flag.
- Idle cycles with changed inputs show that the word is held between strobes.

A randomized phase with a narrow count range then compares the read port on every cycle against a behavioural model. This makes equality and strobe-free cycles frequent.

// File: rtl/usbh_stat_pkg.sv
// Package: shared encodings and field positions for the transaction status word.
// Assumes a 16-bit word; the bit positions are fixed because readers decode them.
package usbh_stat_pkg;
    localparam int STAT_W   = 16;
    localparam int B_ACK    = 0;
    localparam int B_ERR    = 1;
    localparam int B_TMO    = 2;
    localparam int B_SEQ    = 3;
    localparam int B_LENX   = 5;
    localparam int B_NAK    = 6;
    localparam int B_STALL  = 7;
    localparam int B_UNF    = 10;
    localparam int B_OVF    = 11;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic stall;
        logic nak;
        logic lenx;
        logic seq;
        logic tmo;
        logic err;
        logic ack;
    } stat_flags_t;

    localparam int NFLAG = $bits(stat_flags_t);
endpackage

// File: rtl/usbh_len_cmp.sv
// Module: compares the received byte count with the programmed count.
// Assumes both counts are unsigned and the same width. Outputs are forced
// to 0 when the transaction had no IN data stage.
module usbh_len_cmp #(
    parameter int CNT_W = 10
) (
    input  logic             in_stage,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] exp_count,
    output logic             ovf,
    output logic             unf,
    output logic             lenx
);
    // Purpose: magnitude compare, gated by the presence of an IN data stage.
    always_comb begin
        ovf  = in_stage && (rx_count > exp_count);
        unf  = in_stage && (rx_count < exp_count);
        lenx = ovf || unf;
    end
endmodule

// File: rtl/usbh_hs_decode.sv
// Module: classifies the handshake and failure inputs into status flags.
// Assumes the inputs are valid in the cycle of the done strobe. Length
// conditions are not inputs here, so they cannot reach the error flag.
module usbh_hs_decode
    import usbh_stat_pkg::*;
(
    input  logic [1:0] hs_code,
    input  logic       timeout,
    input  logic       crc5_err,
    input  logic       crc16_err,
    input  logic       pid_err,
    input  logic       rx_toggle,
    output logic       ack,
    output logic       nak,
    output logic       stall,
    output logic       tmo,
    output logic       err,
    output logic       seq
);
    hs_e hs;

    // Purpose: map the raw handshake code onto the enumerated type.
    always_comb hs = hs_e'(hs_code);

    // Purpose: derive one flag per outcome class, then a qualified sequence bit.
    always_comb begin
        ack   = (hs == HS_ACK);
        nak   = (hs == HS_NAK);
        stall = (hs == HS_STALL);
        tmo   = timeout;
        err   = crc5_err || crc16_err || pid_err;
        seq   = rx_toggle && ack && !err;
    end
endmodule

// File: rtl/usbh_stat_pack.sv
// Module: places the flag struct into the 16-bit status word.
// Assumes positions from usbh_stat_pkg. Every position not assigned a flag
// is driven 0.
module usbh_stat_pack
    import usbh_stat_pkg::*;
(
    input  stat_flags_t       flags,
    output logic [STAT_W-1:0] word
);
    // Purpose: scatter each flag to its fixed bit, clearing the remaining positions.
    always_comb begin
        word          = '0;
        word[B_ACK]   = flags.ack;
        word[B_ERR]   = flags.err;
        word[B_TMO]   = flags.tmo;
        word[B_SEQ]   = flags.seq;
        word[B_LENX]  = flags.lenx;
        word[B_NAK]   = flags.nak;
        word[B_STALL] = flags.stall;
        word[B_UNF]   = flags.unf;
        word[B_OVF]   = flags.ovf;
    end
endmodule

// File: rtl/usbh_stat_reg.sv
// Module: holding register for the status word, one flop per bit.
// Assumes a synchronous active-low reset. The whole word loads together
// on load.
module usbh_stat_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: per-bit flop, cleared by reset and overwritten on load.
        always_ff @(posedge clk) begin
            if (!rst_n)    q[i] <= 1'b0;
            else if (load) q[i] <= d[i];
        end
    end
endmodule

// File: rtl/usbh_xfer_status.sv
// Module: top of the transaction status capture.
// At each xfer_done it latches a fresh status word built from the
// handshake, failure, toggle and count inputs. It holds the word between
// strobes and presents it on a read-enable gated port.
// Assumes that all transaction inputs are valid in the strobe cycle.
module usbh_xfer_status
    import usbh_stat_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xfer_done,
    input  logic [1:0]         hs_code,
    input  logic               timeout,
    input  logic               crc5_err,
    input  logic               crc16_err,
    input  logic               pid_err,
    input  logic               rx_toggle,
    input  logic               in_stage,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   exp_count,
    input  logic               rd_en,
    output logic [STAT_W-1:0]  rd_data
);
    stat_flags_t       nxt_flags;
    logic [STAT_W-1:0] nxt_word;
    logic [STAT_W-1:0] stat_q;

    usbh_len_cmp #(.CNT_W(CNT_W)) u_len (
        .in_stage  (in_stage),
        .rx_count  (rx_count),
        .exp_count (exp_count),
        .ovf       (nxt_flags.ovf),
        .unf       (nxt_flags.unf),
        .lenx      (nxt_flags.lenx)
    );

    usbh_hs_decode u_dec (
        .hs_code   (hs_code),
        .timeout   (timeout),
        .crc5_err  (crc5_err),
        .crc16_err (crc16_err),
        .pid_err   (pid_err),
        .rx_toggle (rx_toggle),
        .ack       (nxt_flags.ack),
        .nak       (nxt_flags.nak),
        .stall     (nxt_flags.stall),
        .tmo       (nxt_flags.tmo),
        .err       (nxt_flags.err),
        .seq       (nxt_flags.seq)
    );

    usbh_stat_pack u_pack (
        .flags (nxt_flags),
        .word  (nxt_word)
    );

    usbh_stat_reg #(.W(STAT_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (xfer_done),
        .d     (nxt_word),
        .q     (stat_q)
    );

    // Purpose: read port, returning the held word only while enabled.
    always_comb rd_data = rd_en ? stat_q : '0;
endmodule

// File: rtl/usbh_xfer_status_chk.sv
// Module: assertion checker for usbh_xfer_status, attached with bind.
// Relates the strobe-cycle inputs to the held status word one cycle later.
module usbh_xfer_status_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_done,
    input logic [1:0]       hs_code,
    input logic             crc5_err,
    input logic             crc16_err,
    input logic             pid_err,
    input logic             in_stage,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] exp_count,
    input logic             rd_en,
    input logic [15:0]      rd_data,
    input logic [15:0]      stat_q
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done |=> $stable(stat_q));

    assert_overflow_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && in_stage && (rx_count > exp_count)) |=> (stat_q[11] && !stat_q[10]));

    assert_underflow_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && in_stage && (rx_count < exp_count)) |=> (stat_q[10] && !stat_q[11]));

    assert_equal_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && in_stage && (rx_count == exp_count)) |=> (stat_q[5] == 1'b0));

    assert_no_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !in_stage) |=> (stat_q[11:10] == 2'b00 && !stat_q[5]));

    assert_hs_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> $onehot0({stat_q[7], stat_q[6], stat_q[0]}));

    assert_err_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !crc5_err && !crc16_err && !pid_err) |=> !stat_q[1]);

    assert_seq_noack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && hs_code != 2'd1) |=> !stat_q[3]);

    assert_rd_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == 16'h0000));
endmodule

bind usbh_xfer_status usbh_xfer_status_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/usbh_xfer_status_bench.sv
module usbh_xfer_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             xfer_done = 1'b0;
    logic [1:0]       hs_code = '0;
    logic             timeout = 1'b0, crc5_err = 1'b0, crc16_err = 1'b0, pid_err = 1'b0;
    logic             rx_toggle = 1'b0, in_stage = 1'b0, rd_en = 1'b1;
    logic [CNT_W-1:0] rx_count = '0, exp_count = '0;
    logic [15:0]      rd_data;
    logic [15:0]      model_q = 16'h0000;
    int               n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbh_xfer_status #(.CNT_W(CNT_W)) u_usbh_xfer_status (.*);

    // Expected status word for one transaction, written from the requirements.
    function automatic logic [15:0] ref_word();
        logic [15:0] w = 16'h0000;
        bit a = (hs_code == 2'd1);
        bit e = crc5_err | crc16_err | pid_err;
        w[0] = a; w[1] = e; w[2] = timeout; w[3] = rx_toggle & a & ~e;
        w[6] = (hs_code == 2'd2); w[7] = (hs_code == 2'd3);
        if (in_stage) begin
            w[11] = (rx_count > exp_count);
            w[10] = (rx_count < exp_count);
            w[5]  = (rx_count != exp_count);
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) model_q <= 16'h0000;
        else if (xfer_done) model_q <= ref_word();
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic xact(logic [1:0] hs, bit tmo, bit c5, bit c16, bit pe, bit tg,
                        bit ins, int rx, int ex);
        hs_code = hs; timeout = tmo; crc5_err = c5; crc16_err = c16; pid_err = pe;
        rx_toggle = tg; in_stage = ins; rx_count = CNT_W'(rx); exp_count = CNT_W'(ex);
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk); step(); step();
        check("R1 reset", rd_data, 16'h0000);
        rst_n = 1'b1;
        step();
        check("R1 after release", rd_data, 16'h0000);

        xact(2'd1, 0, 0, 0, 0, 1, 1, 65, 64);
        check("R3 overflow", rd_data, 16'h0829);
        xact(2'd1, 0, 0, 0, 0, 0, 1, 63, 64);
        check("R4 underflow", rd_data, 16'h0421);
        xact(2'd1, 0, 0, 0, 0, 1, 1, 64, 64);
        check("R5 equal counts", rd_data, 16'h0009);
        xact(2'd1, 0, 0, 0, 0, 0, 0, 5, 64);
        check("R6 no IN stage", rd_data, 16'h0001);
        xact(2'd2, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 NAK", rd_data, 16'h0040);
        xact(2'd3, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 STALL", rd_data, 16'h0080);
        xact(2'd0, 1, 0, 0, 0, 1, 1, 0, 8);
        check("R8 timeout", rd_data, 16'h0424);
        xact(2'd1, 0, 1, 0, 0, 1, 0, 0, 0);
        check("R9 crc5 err R10 seq cleared", rd_data, 16'h0003);
        xact(2'd1, 0, 0, 1, 0, 1, 0, 0, 0);
        check("R9 crc16 err", rd_data, 16'h0003);
        xact(2'd0, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R9 pid err", rd_data, 16'h0002);
        xact(2'd2, 0, 0, 0, 0, 1, 1, 9, 4);
        check("R10 seq needs ACK, R9 length not error", rd_data, 16'h0860);

        hs_code = 2'd1; crc5_err = 1'b1; in_stage = 1'b1; rx_count = 1; exp_count = 2;
        step(); step();
        check("R2 hold", rd_data, 16'h0860);
        rd_en = 1'b0;
        #1 check("R12 read disabled", rd_data, 16'h0000);
        rd_en = 1'b1;
        #1 check("R12 read enabled", rd_data, 16'h0860);

        for (int i = 0; i < 400; i++) begin
            hs_code = 2'($urandom); timeout = 1'($urandom); crc5_err = ($urandom % 4) == 0;
            crc16_err = ($urandom % 4) == 0; pid_err = ($urandom % 4) == 0;
            rx_toggle = 1'($urandom); in_stage = 1'($urandom);
            rx_count = CNT_W'($urandom % 4); exp_count = CNT_W'($urandom % 4);
            xfer_done = 1'($urandom); rd_en = ($urandom % 8) != 0;
            step();
            check(rd_en ? "R11 R3 R7 random word" : "R12 random gated",
                  rd_data, rd_en ? model_q : 16'h0000);
        end
        finish_run();
    end
endmodule